// File: doc/BRIEF.md
# Deferred Line-Invalidation Queue with Load Fence

This block sits beside one core's private cache and takes in invalidation requests that other agents send for cache lines. A request is accepted and acknowledged in the same cycle it is offered, so the remote writer can go ahead without waiting for the local cache. The line address is parked in a small first-in first-out store, and the actual clear of the local copy is issued later on a dedicated cache-invalidate port. That port drains one entry per cycle whenever the cache has no other work.

Until an entry is drained, local loads may still hit the stale copy, and that is allowed. When the core needs ordering, it pulses a load-fence request. From then on the block drains ahead of all other cache traffic. It raises a one-cycle completion pulse once every entry that was queued when the fence was asked for has been cleared. Entries that arrive after the fence request do not hold it back.

A lookup port reports whether a given line still has an invalidation waiting. The core uses it to hold back any coherence message about that line.

Top module: `lazy_inval_queue`

## Requirements
- R1: While reset is high, and in the cycle that follows it, `clr_valid`, `look_hit` and `fence_done` are 0 and the queue is empty.
- R2: An offered request (`inv_valid`=1) is acknowledged in the same cycle (`inv_ack`=1) whenever fewer than DEPTH entries are held. The address is then appended to the tail of the queue.
- R3: With DEPTH entries held (default 8), `inv_ack` stays 0 and the offered address is not stored, even if an entry drains in that cycle. The held count never exceeds DEPTH.
- R4: When no fence is pending and `cache_busy`=0, one entry per cycle leaves the queue head on `clr_valid`/`clr_addr`, oldest first. When `cache_busy`=1 and no fence is pending, `clr_valid` is 0.
- R5: `look_hit` is 1 in a cycle exactly when at least one held entry equals `look_addr`, including an entry that is being drained in that cycle.
- R6: While a fence is pending, the queue drains one entry per cycle whatever the value of `cache_busy`.
- R7: `fence_done` pulses for one cycle, in the cycle after the last entry that was held when `fence_req` was sampled has drained. If the queue was empty at the request, the pulse comes in the next cycle.
- R8: Entries accepted in or after the cycle of the fence request do not delay `fence_done`.
- R9: A `fence_req` pulse that arrives while a fence is already pending is ignored. It neither restarts the count nor adds a second `fence_done` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_valid | input | 1 | Incoming invalidation request present |
| inv_addr | input | ADDR_W | Line address to invalidate |
| inv_ack | output | 1 | Request accepted and acknowledged this cycle |
| cache_busy | input | 1 | Cache port taken by other traffic this cycle |
| clr_valid | output | 1 | Clear the line state at `clr_addr` this cycle |
| clr_addr | output | ADDR_W | Line address being cleared |
| fence_req | input | 1 | One-cycle load-fence request from the core |
| fence_done | output | 1 | One-cycle pulse: fence ordering satisfied |
| look_addr | input | ADDR_W | Line address to test for a pending invalidation |
| look_hit | output | 1 | A held entry matches `look_addr` |

## Verification
The bench fills the queue while the cache is busy and offers one more request. A design that acknowledged it would lose a line or overwrite the oldest entry. It raises a fence while `cache_busy` is held high: a block that did not force draining would never complete the fence. It also feeds new requests in the fence cycle and after it. A design that counted those would delay `fence_done` or never finish. Fences on an empty queue, repeated fence pulses during a pending fence, and lookups of lines in the same cycle they drain check the exact pulse cycle and the stale-line window. Off-by-one timing there is the likely failure.

// File: rtl/invq_pkg.sv
package invq_pkg;

    // Why the head entry does or does not leave the queue this cycle.
    typedef enum logic [1:0] {
        DRN_IDLE   = 2'd0,   // nothing to drain, or cache port taken
        DRN_FREE   = 2'd1,   // cache port idle, normal lazy drain
        DRN_FORCED = 2'd2    // fence pending, drain ahead of other traffic
    } drain_kind_e;

    // Fence tracker state.
    typedef struct packed {
        logic pending;
        logic done;
    } fence_state_t;

    function automatic drain_kind_e pick_drain(input logic empty,
                                               input logic fence_pend,
                                               input logic busy);
        if (empty)           return DRN_IDLE;
        else if (fence_pend) return DRN_FORCED;
        else if (busy)       return DRN_IDLE;
        else                 return DRN_FREE;
    endfunction

endpackage

// File: rtl/invq_fifo.sv
module invq_fifo #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop,
    input  logic [ADDR_W-1:0] look_addr,
    output logic [ADDR_W-1:0] head_addr,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty,
    output logic              look_hit
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] slot_addr [DEPTH];
    logic [DEPTH-1:0]  slot_vld;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [DEPTH-1:0]  match;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign full      = (count == CAP);
    assign empty     = (count == '0);
    assign head_addr = slot_addr[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            slot_vld <= '0;
        end else begin
            if (pop) begin
                slot_vld[rd_ptr] <= 1'b0;
                rd_ptr           <= step_ptr(rd_ptr);
            end
            if (push) begin
                slot_vld[wr_ptr] <= 1'b1;
                wr_ptr           <= step_ptr(wr_ptr);
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) slot_addr[wr_ptr] <= push_addr;
    end

    // Associative search over every held slot.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = slot_vld[i] && (slot_addr[i] == look_addr);
    end
    assign look_hit = |match;

    // R3: a push is only presented when room exists
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R3: held count bounded
    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        count <= CAP);
    // R2: a lone push grows the queue by exactly one
    p_push_grows_r2: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> count == $past(count) + 1'b1);
    // R5: valid flags track the count that the lookup relies on
    p_vld_count_r5: assert property (@(posedge clk) disable iff (rst)
        $countones(slot_vld) == int'(count));
    // R4: nothing drains from an empty queue
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/invq_fence.sv
module invq_fence
    import invq_pkg::*;
#(
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [CNT_W-1:0] q_count,
    input  logic             pop,
    output fence_state_t     st
);

    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] remain_now;
    logic             start;

    // A request only starts a fence when none is running (R9).
    assign start = req && !st.pending;

    // Entries still owed: snapshot of the held count at the request, never
    // the entries that arrive later (R8), minus the one leaving now.
    always_comb begin
        remain_now = '0;
        if (start)           remain_now = q_count  - CNT_W'(pop);
        else if (st.pending) remain_now = remain_q - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '0;
            remain_q <= '0;
        end else begin
            st.done <= 1'b0;
            if (start || st.pending) begin
                if (remain_now == '0) begin
                    st.pending <= 1'b0;
                    st.done    <= 1'b1;
                end else begin
                    st.pending <= 1'b1;
                end
                remain_q <= remain_now;
            end
        end
    end

    // R7: completion only follows a request or a pending fence
    p_done_cause_r7: assert property (@(posedge clk) disable iff (rst)
        st.done |-> $past(req || st.pending));
    // R8: owed entries never grow while a fence waits
    p_owed_shrinks_r8: assert property (@(posedge clk) disable iff (rst)
        (st.pending && $past(st.pending)) |-> remain_q <= $past(remain_q));
    // R9: completion and pending are never both up
    p_done_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(st.done && st.pending));

endmodule

// File: rtl/lazy_inval_queue.sv
module lazy_inval_queue
    import invq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    output logic              inv_ack,
    input  logic              cache_busy,
    output logic              clr_valid,
    output logic [ADDR_W-1:0] clr_addr,
    input  logic              fence_req,
    output logic              fence_done,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_hit
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             push, pop, q_full, q_empty;
    logic [CNT_W-1:0] q_count;
    fence_state_t     fst;
    drain_kind_e      drain;

    assign push    = inv_valid && !q_full;
    assign inv_ack = push;

    assign drain     = pick_drain(q_empty, fst.pending, cache_busy);
    assign pop       = (drain != DRN_IDLE);
    assign clr_valid = pop;
    assign fence_done = fst.done;

    invq_fifo #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_addr (inv_addr),
        .pop       (pop),
        .look_addr (look_addr),
        .head_addr (clr_addr),
        .count     (q_count),
        .full      (q_full),
        .empty     (q_empty),
        .look_hit  (look_hit)
    );

    invq_fence #(.DEPTH(DEPTH)) u_fence (
        .clk     (clk),
        .rst     (rst),
        .req     (fence_req),
        .q_count (q_count),
        .pop     (pop),
        .st      (fst)
    );

    // R4: a busy cache port with no fence sees no clears
    p_busy_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (cache_busy && !fst.pending) |-> !clr_valid);
    // R6: a pending fence with work queued always drains
    p_forced_drain_r6: assert property (@(posedge clk) disable iff (rst)
        (fst.pending && !q_empty) |-> clr_valid);
    // R1: the first cycle after reset is quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!clr_valid && !fence_done && !look_hit));

endmodule

// File: tb/sim_lazy_inval_queue.sv
`timescale 1ns/1ps
module sim_lazy_inval_queue;

    localparam int AW = 32;
    localparam int DP = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          inv_valid, cache_busy, fence_req;
    logic [AW-1:0] inv_addr, look_addr;
    logic          inv_ack, clr_valid, fence_done, look_hit;
    logic [AW-1:0] clr_addr;

    always #4 clk = ~clk;   // 125 MHz

    lazy_inval_queue #(.ADDR_W(AW), .DEPTH(DP)) u0 (
        .clk(clk), .rst(rst),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ack(inv_ack),
        .cache_busy(cache_busy),
        .clr_valid(clr_valid), .clr_addr(clr_addr),
        .fence_req(fence_req), .fence_done(fence_done),
        .look_addr(look_addr), .look_hit(look_hit)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Reference state built from the requirements.
    logic [AW-1:0] mq [DP];
    int            mcnt;
    logic          mpend, mdone;
    int            mowed;
    int            done_seen;

    task automatic chk(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_w(input logic [AW-1:0] act, input logic [AW-1:0] exp,
                         input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic model_hit(input logic [AW-1:0] a);
        for (int i = 0; i < mcnt; i++)
            if (mq[i] == a) return 1'b1;
        return 1'b0;
    endfunction

    // One cycle: drive at falling edge, check, then advance the model.
    task automatic step(input logic rv, input logic [AW-1:0] ra,
                        input logic busy, input logic fr,
                        input logic [AW-1:0] la, input string dtag);
        logic e_ack, e_pop, start;
        int   rem;
        @(negedge clk);
        inv_valid = rv; inv_addr = ra; cache_busy = busy;
        fence_req = fr; look_addr = la;
        #1;
        e_ack = rv && (mcnt < DP);
        e_pop = (mcnt != 0) && (!busy || mpend);
        chk(inv_ack, e_ack, (mcnt == DP) ? "R3 backpressure" : "R2 ack");
        chk(clr_valid, e_pop, (mpend && busy) ? "R6 forced drain" : "R4 drain");
        if (e_pop) chk_w(clr_addr, mq[0], "R4 order");
        chk(look_hit, model_hit(la), "R5 lookup");
        chk(fence_done, mdone, dtag);
        if (fence_done) done_seen++;
        // model update at the coming edge
        start = fr && !mpend;
        if (start || mpend) begin
            rem = (start ? mcnt : mowed) - (e_pop ? 1 : 0);
            if (rem == 0) begin mdone = 1'b1; mpend = 1'b0; end
            else begin mdone = 1'b0; mpend = 1'b1; end
            mowed = rem;
        end else begin
            mdone = 1'b0;
        end
        if (e_pop) begin
            for (int i = 0; i < DP - 1; i++) mq[i] = mq[i+1];
            mcnt--;
        end
        if (e_ack) begin
            mq[mcnt] = ra;
            mcnt++;
        end
    endtask

    task automatic idle(input logic busy, input string dtag);
        step(1'b0, '0, busy, 1'b0, 32'h5, dtag);
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        inv_valid = 0; inv_addr = '0; cache_busy = 0; fence_req = 0; look_addr = '0;
        mcnt = 0; mpend = 0; mdone = 0; mowed = 0; done_seen = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(clr_valid, 1'b0, "R1 reset clr");
        chk(fence_done, 1'b0, "R1 reset done");
        chk(look_hit, 1'b0, "R1 reset hit");
        rst = 1'b0;
        idle(1'b0, "R1 quiet after reset");

        // R3: fill while cache busy, offer a ninth request
        for (int i = 0; i < DP + 2; i++)
            step(1'b1, 32'h100 + i, 1'b1, 1'b0, 32'h100, "R3 fill");
        chk(model_hit(32'h108), 1'b0, "R3 model sanity");
        step(1'b0, '0, 1'b1, 1'b0, 32'h108, "R3 dropped addr absent");
        // R3: full with a drain in the same cycle still refuses
        step(1'b1, 32'h1FF, 1'b0, 1'b0, 32'h1FF, "R3 full while draining");

        // R6/R7: fence while cache stays busy
        step(1'b0, '0, 1'b1, 1'b1, 32'h101, "R6 fence start");
        for (int i = 0; i < DP + 2; i++) idle(1'b1, "R7 fence drain");
        chk(done_seen, 1'b1, "R7 one done pulse");

        // R7: fence on an empty queue completes next cycle
        done_seen = 0;
        step(1'b0, '0, 1'b1, 1'b1, '0, "R7 empty fence");
        idle(1'b1, "R7 empty fence done");
        chk(done_seen, 1'b1, "R7 empty fence pulse");

        // R8/R9: two entries, fence, then arrivals and a second fence pulse
        done_seen = 0;
        step(1'b1, 32'h20, 1'b1, 1'b0, 32'h20, "R8 setup");
        step(1'b1, 32'h21, 1'b1, 1'b0, 32'h20, "R8 setup");
        step(1'b1, 32'h22, 1'b1, 1'b1, 32'h21, "R8 arrival with fence");
        step(1'b1, 32'h23, 1'b1, 1'b1, 32'h22, "R9 repeat fence ignored");
        step(1'b1, 32'h24, 1'b1, 1'b0, 32'h22, "R8 done despite arrivals");
        step(1'b1, 32'h25, 1'b1, 1'b0, 32'h23, "R8 after done");
        chk(done_seen, 1'b1, "R9 single done pulse");
        for (int i = 0; i < 12; i++) idle(1'b0, "R4 drain rest");

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 3) != 0, $urandom % 16, ($urandom % 4) == 0,
                 ($urandom % 23) == 0, $urandom % 16, "R7 random fence");
        end
        for (int i = 0; i < 12; i++) idle(1'b0, "R4 final drain");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule